// File: doc/BRIEF.md
# Type Tag Extract and Insert Unit

This unit handles the type tag that a dynamically typed runtime keeps next to each 64-bit value in memory. A tagged load fetches the value double-word and the double-word that holds the tag. The unit returns the value unchanged, the extracted 8-bit type tag and an integer/float flag. A tagged store takes a value and a tag, and writes the tag into its field of the tag double-word. Every other bit of that double-word keeps its old value.

Four configuration registers describe the layout used by the running language. They are a signed double-word distance between value and tag, a bit position, an 8-bit field mask, and the tag value that stands for the float type. The unit computes the tag-word address from the value address and does the data transforms. Memory timing and address generation belong to the surrounding pipeline. When the distance is zero, the tag shares the value's double-word, and the unit reads and merges within that one word.

Top module: `tagx_unit`

## Requirements
- R1: After a synchronous reset, all four configuration registers are zero. With a zero mask the extracted tag is 0, the float flag is 1 because the tag equals the zero float tag, and the tag address equals the value address.
- R2: When `cfg_we` is 1 on a clock edge, `cfg_sel` selects the register that is written: 0 is the offset (low 4 bits of `cfg_wdata`, signed), 1 is the shift (low 6 bits), 2 is the mask (8 bits) and 3 is the float tag (8 bits). The new value applies from the next cycle on. When `cfg_we` is 0, all registers keep their values.
- R3: `tag_addr` equals `base_addr` plus the sign-extended offset times 8, modulo 2^ADDR_W.
- R4: `ld_tag` equals (source word >> shift) & mask. The source word is `ld_word_tag` when the offset is nonzero and `ld_word_val` when it is zero. Positions above bit 63 read as zero.
- R5: `ld_is_float` is 1 exactly when `ld_tag` equals the configured float tag.
- R6: `ld_value` equals `ld_word_val` unchanged, whatever the configuration.
- R7: With a nonzero offset, `st_tag_word` is (old & ~(mask << shift)) | ((tag & mask) << shift), cut to 64 bits, where old is `st_old_tag_word`. `st_value_word` equals `st_value`.
- R8: With a zero offset, the same merge is applied to `st_value`, and `st_value_word` and `st_tag_word` both carry the merged word.
- R9: `tag_same_word` is 1 exactly when the offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| base_addr | input | ADDR_W | Byte address of the value double-word |
| tag_addr | output | ADDR_W | Byte address of the tag double-word |
| tag_same_word | output | 1 | Tag lives in the value double-word |
| ld_word_val | input | 64 | Loaded value double-word |
| ld_word_tag | input | 64 | Loaded tag double-word |
| ld_value | output | 64 | Value returned by a tagged load |
| ld_tag | output | 8 | Extracted type tag |
| ld_is_float | output | 1 | Extracted tag denotes the float type |
| st_value | input | 64 | Value to store |
| st_tag | input | 8 | Tag to store |
| st_old_tag_word | input | 64 | Current contents of the tag double-word |
| st_value_word | output | 64 | Double-word to write at the value address |
| st_tag_word | output | 64 | Double-word to write at the tag address |

## Verification
The bench builds the unit with its defaults: 32-bit addresses and a 4-bit offset. At this size every offset from -8 to 7 is swept against the address arithmetic. It also sweeps all 64 shift positions with same-word, next-word and previous-word layouts, under full, sparse and single-bit masks. At high shifts the mask runs past bit 63, which tests the truncation on load and on store. Pseudo-random words and planted float tags drive both outcomes of the float flag. An ignored configuration write is checked through the extracted tag.

// File: rtl/tagx_pkg.sv
package tagx_pkg;

    localparam int DW     = 64;
    localparam int TAG_W  = 8;
    localparam int SH_W   = $clog2(DW);
    localparam int OFF_W  = 4;
    localparam int BYTE_SH = $clog2(DW / 8);

    typedef enum logic [1:0] {
        SEL_OFFSET = 2'd0,
        SEL_SHIFT  = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_FTAG   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [OFF_W-1:0] offset;
        logic [SH_W-1:0]  shift;
        logic [TAG_W-1:0] mask;
        logic [TAG_W-1:0] float_tag;
    } tag_cfg_t;

    function automatic logic [DW-1:0] place_field(input logic [TAG_W-1:0] f,
                                                  input logic [SH_W-1:0]  sh);
        logic [DW-1:0] w;
        w = DW'(f);
        return w << sh;
    endfunction

    function automatic logic [TAG_W-1:0] pick_field(input logic [DW-1:0]    w,
                                                    input logic [SH_W-1:0]  sh,
                                                    input logic [TAG_W-1:0] m);
        logic [DW-1:0] s;
        s = w >> sh;
        return s[TAG_W-1:0] & m;
    endfunction

endpackage

// File: rtl/tagx_cfg_regs.sv
module tagx_cfg_regs
    import tagx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [TAG_W-1:0] wdata,
    output tag_cfg_t         cfg
);

    tag_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_OFFSET: cfg_q.offset    <= wdata[OFF_W-1:0];
                SEL_SHIFT:  cfg_q.shift     <= wdata[SH_W-1:0];
                SEL_MASK:   cfg_q.mask      <= wdata;
                SEL_FTAG:   cfg_q.float_tag <= wdata;
                default:    cfg_q           <= cfg_q;
            endcase
        end
    end

    assign cfg = cfg_q;

    // R1: configuration is cleared by reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == '0));

    // R2: a shift write lands on the next edge
    a_r2_shift_write: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 2'd1) |=> (cfg_q.shift == $past(wdata[SH_W-1:0])));

    // R2: a mask write lands on the next edge
    a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 2'd2) |=> (cfg_q.mask == $past(wdata)));

    // R2: no write, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg_q));

endmodule

// File: rtl/tagx_addr_gen.sv
module tagx_addr_gen
    import tagx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OFF_W-1:0]  offset,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] tag_addr,
    output logic              same_word
);

    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] off_bytes;

    always_comb begin
        off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
        off_bytes = off_ext << BYTE_SH;
        tag_addr  = base_addr + off_bytes;
        same_word = (offset == '0);
    end

    // R3: a zero distance points back at the value word
    a_r3_zero_offset_addr: assert property (@(posedge clk) disable iff (rst)
        same_word |-> (tag_addr == base_addr));

    // R3: the distance is always a whole number of double-words
    a_r3_dword_aligned_step: assert property (@(posedge clk) disable iff (rst)
        ((tag_addr - base_addr) & ADDR_W'((1 << BYTE_SH) - 1)) == '0);

endmodule

// File: rtl/tagx_extract.sv
module tagx_extract
    import tagx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tag_cfg_t         cfg,
    input  logic             same_word,
    input  logic [DW-1:0]    word_val,
    input  logic [DW-1:0]    word_tag,
    output logic [DW-1:0]    value,
    output logic [TAG_W-1:0] tag,
    output logic             is_float
);

    logic [DW-1:0] src;

    always_comb begin
        src      = same_word ? word_val : word_tag;
        tag      = pick_field(src, cfg.shift, cfg.mask);
        is_float = (tag == cfg.float_tag);
        value    = word_val;
    end

    // R4: no tag bit survives outside the mask
    a_r4_tag_within_mask: assert property (@(posedge clk) disable iff (rst)
        (tag & ~cfg.mask) == '0);

    // R5: a set float flag means the tag matches the float code
    a_r5_float_match: assert property (@(posedge clk) disable iff (rst)
        is_float |-> (tag == cfg.float_tag));

endmodule

// File: rtl/tagx_insert.sv
module tagx_insert
    import tagx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tag_cfg_t         cfg,
    input  logic             same_word,
    input  logic [DW-1:0]    st_value,
    input  logic [TAG_W-1:0] st_tag,
    input  logic [DW-1:0]    old_tag_word,
    output logic [DW-1:0]    value_word,
    output logic [DW-1:0]    tag_word
);

    logic [DW-1:0] field;
    logic [DW-1:0] ins;
    logic [DW-1:0] host;
    logic [DW-1:0] merged;

    always_comb begin
        field      = place_field(cfg.mask, cfg.shift);
        ins        = place_field(st_tag & cfg.mask, cfg.shift);
        host       = same_word ? st_value : old_tag_word;
        merged     = (host & ~field) | ins;
        value_word = same_word ? merged : st_value;
        tag_word   = merged;
    end

    // R7: bits outside the tag field pass through from the host word
    a_r7_untouched_bits: assert property (@(posedge clk) disable iff (rst)
        ((tag_word ^ (same_word ? st_value : old_tag_word))
          & ~place_field(cfg.mask, cfg.shift)) == '0);

    // R8: same-word layout writes one merged word
    a_r8_single_word: assert property (@(posedge clk) disable iff (rst)
        same_word |-> (value_word == tag_word));

    // R7: split layout leaves the value untouched
    a_r7_value_passthru: assert property (@(posedge clk) disable iff (rst)
        !same_word |-> (value_word == st_value));

endmodule

// File: rtl/tagx_unit.sv
module tagx_unit
    import tagx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] tag_addr,
    output logic              tag_same_word,
    input  logic [63:0]       ld_word_val,
    input  logic [63:0]       ld_word_tag,
    output logic [63:0]       ld_value,
    output logic [7:0]        ld_tag,
    output logic              ld_is_float,
    input  logic [63:0]       st_value,
    input  logic [7:0]        st_tag,
    input  logic [63:0]       st_old_tag_word,
    output logic [63:0]       st_value_word,
    output logic [63:0]       st_tag_word
);

    tag_cfg_t cfg;
    logic     same;

    tagx_cfg_regs u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    tagx_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .offset    (cfg.offset),
        .base_addr (base_addr),
        .tag_addr  (tag_addr),
        .same_word (same)
    );

    tagx_extract u_ext (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .same_word(same),
        .word_val (ld_word_val),
        .word_tag (ld_word_tag),
        .value    (ld_value),
        .tag      (ld_tag),
        .is_float (ld_is_float)
    );

    tagx_insert u_ins (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .same_word    (same),
        .st_value     (st_value),
        .st_tag       (st_tag),
        .old_tag_word (st_old_tag_word),
        .value_word   (st_value_word),
        .tag_word     (st_tag_word)
    );

    assign tag_same_word = same;

    // R6: the loaded value is never altered
    a_r6_value_intact: assert property (@(posedge clk) disable iff (rst)
        ld_value == ld_word_val);

    // R9: same-word indication follows the split of the tag address
    a_r9_same_flag: assert property (@(posedge clk) disable iff (rst)
        !tag_same_word |-> (tag_addr != base_addr));

endmodule

// File: tb/tagx_unit_bench.sv
`timescale 1ns/1ps
module tagx_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [7:0]  cfg_wdata;
    logic [31:0] base_addr;
    logic [31:0] tag_addr;
    logic        tag_same_word;
    logic [63:0] ld_word_val, ld_word_tag, ld_value;
    logic [7:0]  ld_tag;
    logic        ld_is_float;
    logic [63:0] st_value, st_old_tag_word, st_value_word, st_tag_word;
    logic [7:0]  st_tag;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] lcg = 64'h1234_5678_9abc_def1;

    always #4 clk = ~clk;

    tagx_unit #(.ADDR_W(32)) u_tagx_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .base_addr(base_addr), .tag_addr(tag_addr), .tag_same_word(tag_same_word),
        .ld_word_val(ld_word_val), .ld_word_tag(ld_word_tag), .ld_value(ld_value),
        .ld_tag(ld_tag), .ld_is_float(ld_is_float), .st_value(st_value), .st_tag(st_tag),
        .st_old_tag_word(st_old_tag_word), .st_value_word(st_value_word),
        .st_tag_word(st_tag_word)
    );

    function automatic logic [63:0] rnd();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg ^ (lcg >> 29);
    endfunction

    function automatic logic [7:0] exp_tag(logic [63:0] w, int sh, logic [7:0] m);
        logic [63:0] s;
        s = w >> sh;
        return s[7:0] & m;
    endfunction

    function automatic logic [63:0] exp_merge(logic [63:0] old, logic [7:0] t, int sh,
                                              logic [7:0] m);
        logic [63:0] f, v;
        f = {56'd0, m} << sh;
        v = {56'd0, t & m} << sh;
        return (old & ~f) | v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wcfg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [63:0] w;
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        base_addr = 32'h0000_1000; ld_word_val = 64'hdead_beef_cafe_f00d;
        ld_word_tag = 64'hffff_ffff_ffff_ffff; st_value = 64'h0123_4567_89ab_cdef;
        st_tag = 8'hff; st_old_tag_word = 64'h5555_aaaa_5555_aaaa;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 tag", {56'd0, ld_tag}, 64'd0);
        chk("R1 float", {63'd0, ld_is_float}, 64'd1);
        chk("R1 addr", {32'd0, tag_addr}, {32'd0, base_addr});
        chk("R9 reset same", {63'd0, tag_same_word}, 64'd1);
        chk("R8 reset merge", st_tag_word, st_value);

        // R2: mask write applies, disabled shift write is ignored
        wcfg(2'd2, 8'hff);
        @(negedge clk);
        cfg_we = 1'b0; cfg_sel = 2'd1; cfg_wdata = 8'd8;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R2 ignored write", {56'd0, ld_tag}, {56'd0, ld_word_val[7:0]});
        // R2: float tag write
        wcfg(2'd3, ld_word_val[7:0]);
        #1;
        chk("R2 float tag write", {63'd0, ld_is_float}, 64'd1);

        // R3 / R9: all offsets
        for (int o = -8; o <= 7; o++) begin
            logic [31:0] ea;
            wcfg(2'd0, 8'(o));
            base_addr = rnd()[31:0] & 32'hffff_fff8;
            #1;
            ea = base_addr + 32'(o * 8);
            chk("R3 tag addr", {32'd0, tag_addr}, {32'd0, ea});
            chk("R9 same word", {63'd0, tag_same_word}, {63'd0, o == 0});
        end

        // R4-R8: sweep layouts, shifts and masks
        for (int oi = 0; oi < 3; oi++) begin
            int o;
            o = (oi == 0) ? 0 : ((oi == 1) ? 1 : -1);
            wcfg(2'd0, 8'(o));
            for (int sh = 0; sh < 64; sh++) begin
                for (int mi = 0; mi < 3; mi++) begin
                    logic [7:0] m, ft;
                    m  = (mi == 0) ? 8'hff : ((mi == 1) ? 8'h3c : 8'h01);
                    ft = 8'h5a & m;
                    wcfg(2'd1, 8'(sh));
                    wcfg(2'd2, m);
                    wcfg(2'd3, ft);
                    for (int p = 0; p < 4; p++) begin
                        logic [63:0] src, mg;
                        logic [7:0]  et;
                        @(negedge clk);
                        ld_word_val = rnd(); ld_word_tag = rnd();
                        if (p == 0) begin
                            if (o == 0) ld_word_val = exp_merge(ld_word_val, 8'h5a, sh, 8'hff);
                            else        ld_word_tag = exp_merge(ld_word_tag, 8'h5a, sh, 8'hff);
                        end
                        st_value = rnd(); st_old_tag_word = rnd(); w = rnd(); st_tag = w[7:0];
                        #1;
                        src = (o == 0) ? ld_word_val : ld_word_tag;
                        et  = exp_tag(src, sh, m);
                        chk("R4 extract", {56'd0, ld_tag}, {56'd0, et});
                        chk("R5 float flag", {63'd0, ld_is_float}, {63'd0, et == ft});
                        chk("R6 value", ld_value, ld_word_val);
                        if (o == 0) begin
                            mg = exp_merge(st_value, st_tag, sh, m);
                            chk("R8 value word", st_value_word, mg);
                            chk("R8 tag word", st_tag_word, mg);
                        end else begin
                            mg = exp_merge(st_old_tag_word, st_tag, sh, m);
                            chk("R7 tag word", st_tag_word, mg);
                            chk("R7 value word", st_value_word, st_value);
                        end
                    end
                end
            end
        end

        // R1: reset clears a populated configuration
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 clear tag", {56'd0, ld_tag}, 64'd0);
        chk("R1 clear addr", {32'd0, tag_addr}, {32'd0, base_addr});
        finish_run();
    end

endmodule